// File: doc/BRIEF.md
# Color-Routed Bank Selection Network

This block sits between a set of parallel processing units and a stack of memory banks. It lets every unit issue one read and one write in the same cycle without two of them landing on the same bank. Each stored element carries a color, which is a bank number chosen ahead of time so that elements touched together never share a color. For every request the block looks the color up in a small color table. It then steers the address, and for a write the data word as well, to the bank with that color. Read data is routed back to the unit that asked for it.

Each unit owns a color table with one entry per local slot. A `phase` input selects how the tables are consulted. In the natural phase a unit reads its own table. In the interleaved phase a request is looked up in the table of the unit that owns the element in natural order, so a unit may consult a neighbour's table. The tables are loaded through a configuration write port before decoding starts. Steering uses multiplexers and per-bank enable strobes, not shared tri-state lines. A sticky flag reports any cycle in which two requests of the same kind reach one bank, which only happens when the loaded coloring is invalid.

Top module: `bank_route_net`

## Requirements
- R1: After reset, `rdRespValid` is all zero and `collisionErr` is 0.
- R2: Element index `i` (the low `ADDR_W` bits are the slot `i mod DEPTH`, the upper bits are the owner unit `i / DEPTH`) is stored in the bank whose number equals the element's looked-up color, at bank address `i mod DEPTH`. Changing a color makes later accesses to that element reach the newly named bank.
- R3: A read request accepted in one cycle produces `rdRespValid` for that unit exactly two cycles later, with the read data in that same cycle. In every other cycle `rdRespValid` is low.
- R4: With `phase` = 0 (natural), unit p's request uses unit p's own color table at the slot, and the owner bits of the index have no effect on the lookup.
- R5: With `phase` = 1 (interleaved), a request for element `i` uses the color table of unit `i / DEPTH` at slot `i mod DEPTH`.
- R6: Under a valid coloring, all units' reads and writes issued in one cycle are all carried out, and `collisionErr` stays 0.
- R7: A read and a write to the same element in the same cycle return the value held before that write.
- R8: If two reads, or two writes, issued in one cycle resolve to the same bank, `collisionErr` becomes 1 two cycles later and stays 1 until reset.
- R9: A color table write (`cfgWrEn` with table `cfgTable`, slot `cfgSlot`, color `cfgColor`) applies to every lookup made in any later cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| phase | input | 1 | 0 = natural order lookup, 1 = interleaved order lookup |
| rdReq | input | UNITS | Read request per unit |
| rdIdx | input | UNITS x IDX_W | Element index per read request |
| wrReq | input | UNITS | Write request per unit |
| wrIdx | input | UNITS x IDX_W | Element index per write request |
| wrData | input | UNITS x WORD | Write data per unit |
| cfgWrEn | input | 1 | Color table write strobe |
| cfgTable | input | UNIT_W | Color table selected for the write |
| cfgSlot | input | ADDR_W | Slot written |
| cfgColor | input | COLOR_W | Color value written |
| rdRespValid | output | UNITS | Read response valid per unit |
| rdRespData | output | UNITS x WORD | Read response data per unit |
| collisionErr | output | 1 | Sticky bank collision flag |

## Verification
The main function is exercised in four ways. The first is full-width parallel writes followed by parallel reads in the natural phase, which shows that every unit reaches its own bank and address. The second is reads with foreign owner bits in the natural phase, which separates use of the unit's own table from use of the owner's table. The third is the interleaved phase with rotated owners, which shows that the neighbour table is used. The fourth is recoloring a single element between two writes, which proves that the stored color picks the bank rather than any fixed address bits. A same-element read and write in one cycle pins down read-before-write order. A deliberately clashing pair of reads confirms that the collision flag sets and stays set.

// File: rtl/bank_route_pkg.sv
package bank_route_pkg;
  // Sizing of the network
  localparam int UNITS   = 4;
  localparam int DEPTH   = 16;
  localparam int WORD    = 9;
  localparam int BANKS   = 8;
  // Derived widths
  localparam int ADDR_W  = $clog2(DEPTH);
  localparam int COLOR_W = $clog2(BANKS);
  localparam int UNIT_W  = $clog2(UNITS);
  localparam int IDX_W   = ADDR_W + UNIT_W;

  // Steering strobes from control to datapath, one lane per bank
  typedef struct packed {
    logic [BANKS-1:0]             rdEn;
    logic [BANKS-1:0][UNIT_W-1:0] rdSrc;
    logic [BANKS-1:0]             wrEn;
    logic [BANKS-1:0][UNIT_W-1:0] wrSrc;
  } strobe_t;
endpackage

// File: rtl/bank_route_bank.sv
module bank_route_bank
  import bank_route_pkg::*;
(
  input  logic              clk,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [WORD-1:0]   rdQ,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [WORD-1:0]   wrData
);
  logic [WORD-1:0] mem [DEPTH];

  // Registered read sees the contents before a same-edge write
  always_ff @(posedge clk) begin
    if (rdEn) rdQ <= mem[rdAddr];
    if (wrEn) mem[wrAddr] <= wrData;
  end
endmodule

// File: rtl/bank_route_ctrl.sv
module bank_route_ctrl
  import bank_route_pkg::*;
(
  input  logic                             clk,
  input  logic                             rst,
  input  logic [UNITS-1:0]                 rdValS1,
  input  logic [UNITS-1:0][COLOR_W-1:0]    rdColS1,
  input  logic [UNITS-1:0]                 wrValS1,
  input  logic [UNITS-1:0][COLOR_W-1:0]    wrColS1,
  output strobe_t                          strobes,
  output logic [UNITS-1:0]                 rdRespValid,
  output logic                             collisionErr
);
  logic clash;

  // Per-bank one-of-n selection; the lowest unit wins a shared bank
  always_comb begin
    int rdCnt;
    int wrCnt;
    strobes = '0;
    clash   = 1'b0;
    for (int b = 0; b < BANKS; b++) begin
      rdCnt = 0;
      wrCnt = 0;
      for (int p = UNITS - 1; p >= 0; p--) begin
        if (rdValS1[p] && rdColS1[p] == COLOR_W'(b)) begin
          strobes.rdEn[b]  = 1'b1;
          strobes.rdSrc[b] = UNIT_W'(p);
          rdCnt++;
        end
        if (wrValS1[p] && wrColS1[p] == COLOR_W'(b)) begin
          strobes.wrEn[b]  = 1'b1;
          strobes.wrSrc[b] = UNIT_W'(p);
          wrCnt++;
        end
      end
      if (rdCnt > 1 || wrCnt > 1) clash = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdRespValid  <= '0;
      collisionErr <= 1'b0;
    end else begin
      rdRespValid  <= rdValS1;
      collisionErr <= collisionErr | clash;
    end
  end
endmodule

// File: rtl/bank_route_dp.sv
module bank_route_dp
  import bank_route_pkg::*;
(
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          phase,
  input  logic [UNITS-1:0]              rdReq,
  input  logic [UNITS-1:0][IDX_W-1:0]   rdIdx,
  input  logic [UNITS-1:0]              wrReq,
  input  logic [UNITS-1:0][IDX_W-1:0]   wrIdx,
  input  logic [UNITS-1:0][WORD-1:0]    wrData,
  input  logic                          cfgWrEn,
  input  logic [UNIT_W-1:0]             cfgTable,
  input  logic [ADDR_W-1:0]             cfgSlot,
  input  logic [COLOR_W-1:0]            cfgColor,
  input  strobe_t                       strobes,
  output logic [UNITS-1:0]              rdValS1,
  output logic [UNITS-1:0][COLOR_W-1:0] rdColS1,
  output logic [UNITS-1:0]              wrValS1,
  output logic [UNITS-1:0][COLOR_W-1:0] wrColS1,
  output logic [UNITS-1:0][WORD-1:0]    rdRespData
);
  logic [COLOR_W-1:0] colorTab [UNITS][DEPTH];

  logic [UNITS-1:0][UNIT_W-1:0]  rdSel, wrSel;
  logic [UNITS-1:0][ADDR_W-1:0]  rdAddrS1, wrAddrS1;
  logic [UNITS-1:0][WORD-1:0]    wrDataS1;
  logic [UNITS-1:0][COLOR_W-1:0] rdColS2;
  logic [BANKS-1:0][WORD-1:0]    bankQ;

  // Color tables, loaded by configuration writes
  always_ff @(posedge clk) begin
    if (cfgWrEn) colorTab[cfgTable][cfgSlot] <= cfgColor;
  end

  // Stage 1: table lookup, with address and data held alongside
  for (genvar gp = 0; gp < UNITS; gp++) begin : g_unit
    assign rdSel[gp] = phase ? rdIdx[gp][IDX_W-1:ADDR_W] : UNIT_W'(gp);
    assign wrSel[gp] = phase ? wrIdx[gp][IDX_W-1:ADDR_W] : UNIT_W'(gp);

    always_ff @(posedge clk) begin
      if (rst) begin
        rdValS1[gp] <= 1'b0;
        wrValS1[gp] <= 1'b0;
      end else begin
        rdValS1[gp] <= rdReq[gp];
        wrValS1[gp] <= wrReq[gp];
      end
      rdColS1[gp]  <= colorTab[rdSel[gp]][rdIdx[gp][ADDR_W-1:0]];
      wrColS1[gp]  <= colorTab[wrSel[gp]][wrIdx[gp][ADDR_W-1:0]];
      rdAddrS1[gp] <= rdIdx[gp][ADDR_W-1:0];
      wrAddrS1[gp] <= wrIdx[gp][ADDR_W-1:0];
      wrDataS1[gp] <= wrData[gp];
      // Stage 2: color follows the bank read latency
      rdColS2[gp]  <= rdColS1[gp];
    end

    assign rdRespData[gp] = bankQ[rdColS2[gp]];
  end

  // Bank stack with multiplexed steering
  for (genvar gb = 0; gb < BANKS; gb++) begin : g_bank
    bank_route_bank u_bank (
      .clk    (clk),
      .rdEn   (strobes.rdEn[gb]),
      .rdAddr (rdAddrS1[strobes.rdSrc[gb]]),
      .rdQ    (bankQ[gb]),
      .wrEn   (strobes.wrEn[gb]),
      .wrAddr (wrAddrS1[strobes.wrSrc[gb]]),
      .wrData (wrDataS1[strobes.wrSrc[gb]])
    );
  end
endmodule

// File: rtl/bank_route_net.sv
module bank_route_net
  import bank_route_pkg::*;
(
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          phase,
  input  logic [UNITS-1:0]              rdReq,
  input  logic [UNITS-1:0][IDX_W-1:0]   rdIdx,
  input  logic [UNITS-1:0]              wrReq,
  input  logic [UNITS-1:0][IDX_W-1:0]   wrIdx,
  input  logic [UNITS-1:0][WORD-1:0]    wrData,
  input  logic                          cfgWrEn,
  input  logic [UNIT_W-1:0]             cfgTable,
  input  logic [ADDR_W-1:0]             cfgSlot,
  input  logic [COLOR_W-1:0]            cfgColor,
  output logic [UNITS-1:0]              rdRespValid,
  output logic [UNITS-1:0][WORD-1:0]    rdRespData,
  output logic                          collisionErr
);
  strobe_t                       strobes;
  logic [UNITS-1:0]              rdValS1, wrValS1;
  logic [UNITS-1:0][COLOR_W-1:0] rdColS1, wrColS1;

  bank_route_dp u_dp (
    .clk, .rst, .phase, .rdReq, .rdIdx, .wrReq, .wrIdx, .wrData,
    .cfgWrEn, .cfgTable, .cfgSlot, .cfgColor, .strobes,
    .rdValS1, .rdColS1, .wrValS1, .wrColS1, .rdRespData
  );

  bank_route_ctrl u_ctrl (
    .clk, .rst, .rdValS1, .rdColS1, .wrValS1, .wrColS1,
    .strobes, .rdRespValid, .collisionErr
  );
endmodule

// File: rtl/bank_route_chk.sv
module bank_route_chk
  import bank_route_pkg::*;
(
  input logic             clk,
  input logic             rst,
  input logic [UNITS-1:0] rdReq,
  input logic [UNITS-1:0] wrReq,
  input logic [UNITS-1:0] rdRespValid,
  input logic             collisionErr
);
  logic [1:0] sinceRst;

  always_ff @(posedge clk) begin
    if (rst) sinceRst <= '0;
    else if (sinceRst != 2'd3) sinceRst <= sinceRst + 2'd1;
  end

  assert_reset_state_R1: assert property (@(posedge clk) disable iff (rst)
    (sinceRst == 2'd1) |-> (rdRespValid == '0 && !collisionErr));

  assert_read_latency_R3: assert property (@(posedge clk) disable iff (rst)
    (sinceRst >= 2'd2) |-> (rdRespValid == $past(rdReq, 2)));

  assert_sticky_flag_R8: assert property (@(posedge clk) disable iff (rst)
    $past(collisionErr) |-> collisionErr);

  assert_flag_cause_R8: assert property (@(posedge clk) disable iff (rst)
    ((sinceRst >= 2'd2) && $rose(collisionErr)) |->
      ($countones($past(rdReq, 2)) >= 2 || $countones($past(wrReq, 2)) >= 2));
endmodule

bind bank_route_net bank_route_chk u_chk (
  .clk          (clk),
  .rst          (rst),
  .rdReq        (rdReq),
  .wrReq        (wrReq),
  .rdRespValid  (rdRespValid),
  .collisionErr (collisionErr)
);

// File: tb/bank_route_net_bench.sv
`timescale 1ns/1ps
module bank_route_net_bench;
  import bank_route_pkg::*;

  logic                          clk = 1'b0;
  logic                          rst = 1'b1;
  logic                          phase = 1'b0;
  logic [UNITS-1:0]              rdReq = '0;
  logic [UNITS-1:0][IDX_W-1:0]   rdIdx = '0;
  logic [UNITS-1:0]              wrReq = '0;
  logic [UNITS-1:0][IDX_W-1:0]   wrIdx = '0;
  logic [UNITS-1:0][WORD-1:0]    wrData = '0;
  logic                          cfgWrEn = 1'b0;
  logic [UNIT_W-1:0]             cfgTable = '0;
  logic [ADDR_W-1:0]             cfgSlot = '0;
  logic [COLOR_W-1:0]            cfgColor = '0;
  logic [UNITS-1:0]              rdRespValid;
  logic [UNITS-1:0][WORD-1:0]    rdRespData;
  logic                          collisionErr;

  int compared = 0;
  int mismatched = 0;
  bit finished = 1'b0;

  int              ctab [UNITS][DEPTH];
  logic [WORD-1:0] mdl  [BANKS][DEPTH];

  always #2 clk = ~clk;

  bank_route_net u_bank_route_net (
    .clk, .rst, .phase, .rdReq, .rdIdx, .wrReq, .wrIdx, .wrData,
    .cfgWrEn, .cfgTable, .cfgSlot, .cfgColor,
    .rdRespValid, .rdRespData, .collisionErr
  );

  task automatic check(input string req, input int act, input int exp, input string what);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic int colorOf(input int p, input logic [IDX_W-1:0] idx);
    int t;
    t = phase ? int'(idx[IDX_W-1:ADDR_W]) : p;
    return ctab[t][idx[ADDR_W-1:0]];
  endfunction

  // Called at a negedge with requests already applied; returns at a negedge
  task automatic runOp(input string req);
    logic [UNITS-1:0][WORD-1:0] expd;
    logic [UNITS-1:0]           expV;
    expd = '0;
    expV = rdReq;
    for (int p = 0; p < UNITS; p++)
      if (rdReq[p]) expd[p] = mdl[colorOf(p, rdIdx[p])][rdIdx[p][ADDR_W-1:0]];
    for (int p = 0; p < UNITS; p++)
      if (wrReq[p]) mdl[colorOf(p, wrIdx[p])][wrIdx[p][ADDR_W-1:0]] = wrData[p];
    @(negedge clk);
    rdReq = '0;
    wrReq = '0;
    check("R3", int'(rdRespValid), 0, "valid one cycle after request");
    @(negedge clk);
    check("R3", int'(rdRespValid), int'(expV), "valid two cycles after request");
    for (int p = 0; p < UNITS; p++)
      if (expV[p]) check(req, int'(rdRespData[p]), int'(expd[p]), "read data");
  endtask

  task automatic cfgWrite(input int t, input int s, input int c);
    cfgWrEn  = 1'b1;
    cfgTable = UNIT_W'(t);
    cfgSlot  = ADDR_W'(s);
    cfgColor = COLOR_W'(c);
    ctab[t][s] = c;
    @(negedge clk);
    cfgWrEn = 1'b0;
  endtask

  task automatic testReset();
    check("R1", int'(rdRespValid), 0, "response valid after reset");
    check("R1", int'(collisionErr), 0, "collision flag after reset");
  endtask

  task automatic loadColoring();
    for (int t = 0; t < UNITS; t++)
      for (int s = 0; s < DEPTH; s++)
        cfgWrite(t, s, (t + s) % UNITS);
  endtask

  // R6 and R4: every unit writes, then reads, its own elements in parallel
  task automatic testNaturalParallel();
    phase = 1'b0;
    for (int s = 0; s < DEPTH; s++) begin
      for (int p = 0; p < UNITS; p++) begin
        wrReq[p]  = 1'b1;
        wrIdx[p]  = IDX_W'(p * DEPTH + s);
        wrData[p] = WORD'(p * 37 + s * 5 + 1);
      end
      runOp("R6");
    end
    for (int s = 0; s < DEPTH; s++) begin
      for (int p = 0; p < UNITS; p++) begin
        rdReq[p] = 1'b1;
        rdIdx[p] = IDX_W'(p * DEPTH + s);
      end
      runOp("R6");
    end
    check("R6", int'(collisionErr), 0, "flag after valid parallel traffic");
  endtask

  // R4: owner bits ignored in natural phase
  task automatic testNaturalOwnerBits();
    phase = 1'b0;
    for (int s = 0; s < DEPTH; s += 3) begin
      for (int p = 0; p < UNITS; p++) begin
        rdReq[p] = 1'b1;
        rdIdx[p] = IDX_W'(((p + 2) % UNITS) * DEPTH + s);
      end
      runOp("R4");
    end
  endtask

  // R5: interleaved phase consults the owner's table
  task automatic testInterleaved();
    phase = 1'b1;
    for (int s = 0; s < DEPTH; s++) begin
      for (int p = 0; p < UNITS; p++) begin
        rdReq[p] = 1'b1;
        rdIdx[p] = IDX_W'(((p + 1) % UNITS) * DEPTH + s);
      end
      runOp("R5");
    end
    phase = 1'b0;
  endtask

  // R2 and R9: recoloring one element moves it to another bank
  task automatic testRecolor();
    phase = 1'b0;
    wrReq[0] = 1'b1; wrIdx[0] = IDX_W'(5); wrData[0] = WORD'(9'h1A5);
    runOp("R2");
    cfgWrite(0, 5, 6);
    wrReq[0] = 1'b1; wrIdx[0] = IDX_W'(5); wrData[0] = WORD'(9'h05A);
    runOp("R2");
    rdReq[0] = 1'b1; rdIdx[0] = IDX_W'(5);
    runOp("R9");
    check("R2", int'(rdRespData[0]), 9'h05A, "data from bank 6");
    cfgWrite(0, 5, 1);
    rdReq[0] = 1'b1; rdIdx[0] = IDX_W'(5);
    runOp("R9");
    check("R2", int'(rdRespData[0]), 9'h1A5, "data back in bank 1");
  endtask

  // R7: read and write of one element in one cycle give the old value
  task automatic testReadBeforeWrite();
    phase = 1'b0;
    rdReq[2] = 1'b1; rdIdx[2] = IDX_W'(2 * DEPTH + 7);
    wrReq[2] = 1'b1; wrIdx[2] = IDX_W'(2 * DEPTH + 7); wrData[2] = WORD'(9'h133);
    runOp("R7");
    check("R7", int'(rdRespData[2]), int'(WORD'(2 * 37 + 7 * 5 + 1)), "old value");
    rdReq[2] = 1'b1; rdIdx[2] = IDX_W'(2 * DEPTH + 7);
    runOp("R7");
    check("R7", int'(rdRespData[2]), 9'h133, "new value next access");
  endtask

  // R8: two reads to one bank set the sticky flag
  task automatic testCollision();
    phase = 1'b0;
    check("R8", int'(collisionErr), 0, "flag before clash");
    rdReq[0] = 1'b1; rdIdx[0] = IDX_W'(0);
    rdReq[1] = 1'b1; rdIdx[1] = IDX_W'(DEPTH + 3);
    @(negedge clk);
    rdReq = '0;
    check("R8", int'(collisionErr), 0, "flag one cycle after clash");
    @(negedge clk);
    check("R8", int'(collisionErr), 1, "flag two cycles after clash");
    repeat (5) @(negedge clk);
    check("R8", int'(collisionErr), 1, "flag still set");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    @(negedge clk);
    testReset();
    loadColoring();
    testNaturalParallel();
    testNaturalOwnerBits();
    testInterleaved();
    testRecolor();
    testReadBeforeWrite();
    testCollision();
    finished = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      compared++;
      mismatched++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule